// File: doc/BRIEF.md
# Power-On Strap Capture Controller

This block manages five pins that serve two purposes. While power-on reset is held, they act as configuration straps. Once reset ends, they become clock outputs. For the whole reset period the block keeps the output drivers of these pins off and samples their levels on every clock. When reset is released it keeps the last sampled set, and on the next clock edge it turns the drivers on. The kept set does not change until reset is asserted again.

The captured set has three parts: a three-bit frequency code, an operating-mode bit and a CPU buffer supply bit. The mode bit decides what two further shared pins do. In desktop mode they drive extra clocks, so their drivers are enabled and both stop requests toward the clock-gating logic are held deasserted. In mobile mode they are inputs that carry active-low CPU-stop and PCI-stop requests. These requests are asynchronous, so they pass through a synchronizer before they reach the gating logic.

The frequency code is also expanded into a one-hot select for the synthesizer. The live spread-spectrum enable and type inputs are decoded into a separate flag for each spread mode. Frequency synthesis and modulation are done elsewhere.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While `rst` is high, every bit of `strap_oe` and `shared_oe` is 0.
- R2: On the first rising clock edge with `rst` low, `strap_oe` becomes all ones, and it stays all ones while reset remains low.
- R3: The captured configuration equals `strap_in` as sampled on the last rising edge at which `rst` was high. The bit fields are: [2:0] frequency code on `cfg_fsel`, [3] mode on `desktop_mode` (1 = desktop, 0 = mobile), [4] supply select on `cpu_2v5` (1 = 2.5 V buffers, 0 = 3.3 V).
- R4: After reset is released, changes on `strap_in` have no effect on `cfg_fsel`, `desktop_mode`, `cpu_2v5` or `freq_sel`.
- R5: With desktop mode captured and reset low, `shared_oe` is 2'b11, and `cpu_stop_n` and `pci_stop_n` stay 1 whatever `shared_in` carries.
- R6: With mobile mode captured and reset low, `shared_oe` is 2'b00. `cpu_stop_n` follows `shared_in[0]` and `pci_stop_n` follows `shared_in[1]`, each with exactly two rising edges of latency.
- R7: `freq_sel` is one-hot, with bit number `cfg_fsel` set.
- R8: `cpu_2v5` reports the captured supply bit (strap bit 4).
- R9: Spread decode is combinational from the live inputs. With `ss_en_n` = 0 and `ss_type` = 1 only `ss_down` is set. With `ss_en_n` = 0 and `ss_type` = 0 only `ss_center` is set. `ss_active` equals the inverse of `ss_en_n`. With `ss_en_n` = 1 all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_in | input | 5 | Levels seen on the five dual-purpose pins |
| shared_in | input | 2 | Levels on the two mode-dependent pins: [0] CPU stop, [1] PCI stop (active low) |
| ss_en_n | input | 1 | Spread-spectrum enable, active low |
| ss_type | input | 1 | Spread type: 1 = down, 0 = center |
| strap_oe | output | 5 | Output-driver enables for the strap pins |
| shared_oe | output | 2 | Output-driver enables for the shared pins |
| cfg_fsel | output | 3 | Captured frequency code |
| freq_sel | output | 8 | One-hot expansion of the frequency code |
| desktop_mode | output | 1 | Captured mode bit |
| cpu_2v5 | output | 1 | Captured CPU buffer supply select |
| cpu_stop_n | output | 1 | Synchronized CPU stop request, active low |
| pci_stop_n | output | 1 | Synchronized PCI stop request, active low |
| ss_active | output | 1 | Spread spectrum is on |
| ss_down | output | 1 | Down-spread selected |
| ss_center | output | 1 | Center-spread selected |

## Verification
Some properties are checked on every cycle outside reset: the strap drivers stay enabled, the captured set is frozen, the one-hot select has exactly one bit, the two spread flags exclude each other, and enabled shared drivers always come with deasserted stop requests. Other behaviour only shows up in the bench's sequences. This covers which edge's sample gets captured when the straps change in the last reset cycle, the exact release edge on which the drivers turn on, the two-edge latency of each stop request in mobile mode, and the mapping of every frequency code and mode combination.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
    localparam int FSEL_W   = 3;
    localparam int NUM_FREQ = 1 << FSEL_W;
    localparam int STRAP_W  = FSEL_W + 2;
    localparam int SHARED_W = 2;

    typedef struct packed {
        logic              cpu_2v5;
        logic              desktop;
        logic [FSEL_W-1:0] fsel;
    } strap_t;

    typedef struct packed {
        logic active;
        logic down;
        logic center;
    } spread_t;

    function automatic spread_t decode_spread(input logic en_n, input logic typ);
        spread_t s;
        s.active = ~en_n;
        s.down   = ~en_n & typ;
        s.center = ~en_n & ~typ;
        return s;
    endfunction

    function automatic logic [NUM_FREQ-1:0] fsel_onehot(input logic [FSEL_W-1:0] f);
        logic [NUM_FREQ-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_FREQ; k++) begin
            if (f == FSEL_W'(k)) v[k] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strap_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t pins_in,
    output strap_t cap_q,
    output logic   drive_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= pins_in;
            drive_en <= 1'b0;
        end else begin
            drive_en <= 1'b1;
        end
    end

    AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drive_en); // R2

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cap_q)); // R4
endmodule

// File: rtl/stop_sync.sv
module stop_sync #(
    parameter int CH     = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] async_n,
    output logic [CH-1:0] sync_n
);
    localparam int LAST = STAGES - 1;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [STAGES-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst) sr <= '1;
            else     sr <= {sr[STAGES-2:0], async_n[c]};
        end
        assign sync_n[c] = sr[LAST];
    end
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
    import strap_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STRAP_W-1:0]  strap_in,
    input  logic [SHARED_W-1:0] shared_in,
    input  logic                ss_en_n,
    input  logic                ss_type,
    output logic [STRAP_W-1:0]  strap_oe,
    output logic [SHARED_W-1:0] shared_oe,
    output logic [FSEL_W-1:0]   cfg_fsel,
    output logic [NUM_FREQ-1:0] freq_sel,
    output logic                desktop_mode,
    output logic                cpu_2v5,
    output logic                cpu_stop_n,
    output logic                pci_stop_n,
    output logic                ss_active,
    output logic                ss_down,
    output logic                ss_center
);
    strap_t                cap;
    logic                  drive_en;
    logic [SHARED_W-1:0]   stop_sync_n;
    spread_t               spread;

    strap_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .pins_in  (strap_t'(strap_in)),
        .cap_q    (cap),
        .drive_en (drive_en)
    );

    stop_sync #(.CH(SHARED_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (shared_in),
        .sync_n  (stop_sync_n)
    );

    always_comb begin
        strap_oe     = {STRAP_W{drive_en}};
        shared_oe    = {SHARED_W{drive_en & cap.desktop}};
        cfg_fsel     = cap.fsel;
        freq_sel     = fsel_onehot(cap.fsel);
        desktop_mode = cap.desktop;
        cpu_2v5      = cap.cpu_2v5;
        cpu_stop_n   = cap.desktop | stop_sync_n[0];
        pci_stop_n   = cap.desktop | stop_sync_n[1];
        spread       = decode_spread(ss_en_n, ss_type);
        ss_active    = spread.active;
        ss_down      = spread.down;
        ss_center    = spread.center;
    end

    AST_SHARED_DRIVE_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        (shared_oe != '0) |-> (cpu_stop_n && pci_stop_n)); // R5

    AST_FREQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(freq_sel) == 1); // R7

    AST_SPREAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ss_down && ss_center)); // R9
endmodule

// File: tb/test_strap_capture_ctrl.sv
`timescale 1ns/1ps
module test_strap_capture_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] strap_in = '0;
    logic [1:0] shared_in = 2'b11;
    logic       ss_en_n = 1'b1;
    logic       ss_type = 1'b0;
    logic [4:0] strap_oe;
    logic [1:0] shared_oe;
    logic [2:0] cfg_fsel;
    logic [7:0] freq_sel;
    logic       desktop_mode, cpu_2v5, cpu_stop_n, pci_stop_n;
    logic       ss_active, ss_down, ss_center;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    strap_capture_ctrl i_strap_capture_ctrl (
        .clk(clk), .rst(rst), .strap_in(strap_in), .shared_in(shared_in),
        .ss_en_n(ss_en_n), .ss_type(ss_type), .strap_oe(strap_oe),
        .shared_oe(shared_oe), .cfg_fsel(cfg_fsel), .freq_sel(freq_sel),
        .desktop_mode(desktop_mode), .cpu_2v5(cpu_2v5), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .ss_active(ss_active), .ss_down(ss_down),
        .ss_center(ss_center)
    );

    // vector: [6] ss_type, [5] ss_en_n, [4] supply, [3] mode, [2:0] fsel
    localparam logic [6:0] VEC [8] = '{
        7'b0_0_0_1_000, 7'b1_0_1_0_001, 7'b0_1_0_0_010, 7'b1_1_1_1_011,
        7'b1_0_0_1_100, 7'b0_0_1_0_101, 7'b1_1_1_0_110, 7'b0_1_0_1_111
    };

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_cfg(input logic [4:0] s, input string req);
        check(cfg_fsel == s[2:0], {req, " fsel"}, cfg_fsel, s[2:0]);
        check(desktop_mode == s[3], {req, " mode"}, desktop_mode, s[3]);
        check(cpu_2v5 == s[4], {req, " R8 supply"}, cpu_2v5, s[4]);
        check(freq_sel == (8'd1 << s[2:0]), {req, " R7 onehot"}, freq_sel, 8'd1 << s[2:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1;
        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            logic       dk, lo_en;
            v  = VEC[i];
            dk = v[3];
            rst = 1'b1;
            strap_in = v[4:0];
            shared_in = 2'b00;
            ss_en_n = v[5];
            ss_type = v[6];
            tick(3);
            check(strap_oe == 5'b0, "R1 strap_oe in reset", strap_oe, 0);
            check(shared_oe == 2'b0, "R1 shared_oe in reset", shared_oe, 0);
            rst = 1'b0;
            tick(1);
            check(strap_oe == 5'b11111, "R2 strap_oe after release", strap_oe, 5'h1f);
            check(shared_oe == (dk ? 2'b11 : 2'b00), "R5/R6 shared_oe", shared_oe, dk ? 3 : 0);
            check_cfg(v[4:0], "R3");
            lo_en = ~v[5];
            check(ss_active == lo_en, "R9 active", ss_active, lo_en);
            check(ss_down == (lo_en & v[6]), "R9 down", ss_down, lo_en & v[6]);
            check(ss_center == (lo_en & ~v[6]), "R9 center", ss_center, lo_en & ~v[6]);
            strap_in = ~v[4:0];
            tick(2);
            check_cfg(v[4:0], "R4 frozen");
            check(strap_oe == 5'b11111, "R2 strap_oe held", strap_oe, 5'h1f);
            if (dk) begin
                check({pci_stop_n, cpu_stop_n} == 2'b11, "R5 stops high", {pci_stop_n, cpu_stop_n}, 3);
            end else begin
                check({pci_stop_n, cpu_stop_n} == 2'b00, "R6 stops follow", {pci_stop_n, cpu_stop_n}, 0);
                shared_in = 2'b01;
                tick(1);
                check({pci_stop_n, cpu_stop_n} == 2'b00, "R6 latency", {pci_stop_n, cpu_stop_n}, 0);
                tick(1);
                check({pci_stop_n, cpu_stop_n} == 2'b01, "R6 cpu stop", {pci_stop_n, cpu_stop_n}, 1);
                shared_in = 2'b10;
                tick(2);
                check({pci_stop_n, cpu_stop_n} == 2'b10, "R6 pci stop", {pci_stop_n, cpu_stop_n}, 2);
            end
        end

        // R3: capture holds the last reset-edge sample
        rst = 1'b1;
        strap_in = 5'b01010;
        tick(2);
        strap_in = 5'b10101;
        tick(1);
        rst = 1'b0;
        strap_in = 5'b01111;
        tick(1);
        check_cfg(5'b10101, "R3 last sample");
        check(strap_oe == 5'b11111, "R2 single edge", strap_oe, 5'h1f);

        // R1: reset reasserted mid-run drops drivers on its first edge
        rst = 1'b1;
        strap_in = 5'b01000;
        tick(1);
        check(strap_oe == 5'b0, "R1 reassert", strap_oe, 0);
        check(shared_oe == 2'b0, "R1 reassert shared", shared_oe, 0);
        rst = 1'b0;
        shared_in = 2'b00;
        tick(1);
        check(shared_oe == 2'b11, "R5 desktop oe", shared_oe, 3);
        tick(2);
        check({pci_stop_n, cpu_stop_n} == 2'b11, "R5 stops forced", {pci_stop_n, cpu_stop_n}, 3);

        // R9: live spread inputs after release
        ss_en_n = 1'b0; ss_type = 1'b1; #1;
        check({ss_active, ss_down, ss_center} == 3'b110, "R9 live down", {ss_active, ss_down, ss_center}, 6);
        ss_type = 1'b0; #1;
        check({ss_active, ss_down, ss_center} == 3'b101, "R9 live center", {ss_active, ss_down, ss_center}, 5);
        ss_en_n = 1'b1; #1;
        check({ss_active, ss_down, ss_center} == 3'b000, "R9 live off", {ss_active, ss_down, ss_center}, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule